// File: doc/BRIEF.md
# SPI NOR Flash Burst Read Engine

This block sits on the host side of a single-bit SPI link to a serial NOR flash. A request gives a start address, a byte count and a mode bit. The engine then runs a complete read transaction on the SPI pins, with no further involvement from the requester.

First it pulls chip select low. It shifts out a read opcode and the 24-bit address, MSB first. For the fast command it also sends eight dummy clocks. It then clocks in data bytes and hands each one out on a valid/ready byte stream, together with the flash address that byte came from. After the last byte it releases chip select. SCK is derived from the system clock by a runtime divider.

The engine knows the nominal system clock frequency. When a plain read is requested at an SCK rate above the plain-read ceiling, it issues the fast command instead. Backpressure on the byte stream freezes SCK low until the waiting byte is taken. Address tracking wraps at the top of the 4 Mbyte (32 Mbit) array.

Top module: `flash_rd_engine`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `spi_cs_n` is 1, `spi_sck` is 0, `out_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: A plain read sends opcode 0x03 and then the 24-bit start address, MSB first, with no dummy bits. The first data bit is sampled on the 33rd rising SCK edge.
- R3: A fast read sends opcode 0x0B, then the address, then 8 dummy bits driven as 0. The first data bit is sampled on the 41st rising edge. `spi_mosi` is 0 for every bit after the header.
- R4: SCK frequency is SYS_HZ / (2*(cfg_div+1)), with SYS_HZ = 200 MHz by default. When this exceeds 33 MHz (cfg_div of 0, 1 or 2), a request with `req_fast`=0 is sent as a fast read (0x0B).
- R5: SPI mode 0 is used. SCK rests low, and SCK is high only while `spi_cs_n` is low. `spi_mosi` changes only at falling SCK edges or when chip select falls. MISO is sampled on rising edges.
- R6: Each byte is presented on `out_data` with `out_valid` high. `out_data` and `out_addr` hold steady until `out_ready` is seen. Bytes arrive in address order, first bit received in bit 7.
- R7: The start address is reduced to its low 22 bits, both on the bus and in `out_addr`. `out_addr` rises by one per byte and wraps from 0x3FFFFF to 0x000000. `out_data` equals the flash byte at that address.
- R8: While a completed byte waits with `out_ready` low, SCK is held low. No further rising edge occurs until the byte is taken.
- R9: `spi_cs_n` stays low for the whole transaction, which has exactly header+8*count rising edges. It rises with SCK low after the last byte, and `done` pulses for one cycle as it rises.
- R10: Between transactions, `spi_cs_n` stays high for at least `cfg_gap` system clocks.
- R11: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low whenever a transaction is in progress.
- R12: A request with count 0 is accepted and raises `done` in the next cycle. Chip select is never asserted for it.
- R13: Levels on `spi_miso` during the opcode, address and dummy bits have no effect on the delivered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and inter-transaction gap met |
| req_addr | input | 24 | Start byte address |
| req_len | input | 16 | Number of bytes to read |
| req_fast | input | 1 | 1 selects the fast command with dummy clocks |
| cfg_div | input | 8 | SCK half-period in system clocks, minus one |
| cfg_gap | input | 8 | Minimum chip-select high time in system clocks |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| out_valid | output | 1 | Data byte available |
| out_data | output | 8 | Data byte |
| out_addr | output | 24 | Flash address of `out_data` |
| out_ready | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle pulse at end of a request |

## Verification
Some properties are checked on every cycle:
- SCK low whenever chip select is high, and MOSI changing only with SCK low.
- The output byte and address held under backpressure, and SCK frozen low while a byte waits.
- `done` coinciding with chip-select release.
- The gap rule at each chip-select fall.
- `req_ready` dropping during a transaction.
- Immediate completion of zero-length requests.

Other behaviour can only be shown by the bench's scenarios, which run a bus-level flash model:
- The opcode choice, including promotion at the 33 MHz boundary.
- The transmitted address and the exact rising-edge count.
- The byte values and the wrap of `out_addr` across 0x3FFFFF.
- The rejection of MISO noise in the header.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FINISH
  } seq_state_t;

  localparam logic [7:0] OP_PLAIN = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
endpackage

// File: rtl/flash_rd_sck_gen.sv
module flash_rd_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  // Half-period counter: a tick toggles SCK
  assign tick = en && (cnt >= div);
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (en) begin
      if (tick) begin
        cnt <= '0;
        sck <= ~sck;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_rd_addr_track.sv
module flash_rd_addr_track #(
  parameter int AW       = 24,
  parameter int ARRAY_AW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] ADDR_MASK = {{(AW-ARRAY_AW){1'b0}}, {ARRAY_AW{1'b1}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (load) begin
      cur <= load_addr & ADDR_MASK;
    end else if (step) begin
      cur <= (cur + 1'b1) & ADDR_MASK;
    end
  end
endmodule

// File: rtl/flash_rd_gap_timer.sv
module flash_rd_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic [GAP_W-1:0] gap,
  output logic             ok
);
  logic [GAP_W-1:0] cnt;

  // cnt+1 is the high time chip select will have had at the next edge
  assign ok = ({1'b0, cnt} + (GAP_W+1)'(1)) >= {1'b0, gap};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (!cs_n) begin
      cnt <= '0;
    end else if (cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_rd_engine.sv
module flash_rd_engine
  import flash_rd_pkg::*;
#(
  parameter int SYS_HZ       = 200_000_000,
  parameter int PLAIN_MAX_HZ = 33_000_000,
  parameter int DIV_W        = 8,
  parameter int LEN_W        = 16,
  parameter int GAP_W        = 8,
  parameter int AW           = 24,
  parameter int ARRAY_AW     = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_fast,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [AW-1:0]    out_addr,
  input  logic             out_ready,
  output logic             done
);
  localparam int TX_W          = AW + 16;
  localparam int HDR_PLAIN     = AW + 8;
  localparam int HDR_FAST      = AW + 16;
  localparam int HDR_W         = $clog2(HDR_FAST + 1);
  localparam int MIN_PLAIN_DIV = (SYS_HZ + 2*PLAIN_MAX_HZ - 1) / (2*PLAIN_MAX_HZ) - 1;
  localparam logic [AW-1:0] ADDR_MASK = {{(AW-ARRAY_AW){1'b0}}, {ARRAY_AW{1'b1}}};

  seq_state_t       state;
  logic [TX_W-1:0]  tx;
  logic [HDR_W-1:0] hdr_left;
  logic             in_data;
  logic [2:0]       bcnt;
  logic [7:0]       rx;
  logic [LEN_W-1:0] rem;
  logic             cs_n_q;
  logic             done_q;
  logic             ov_q;
  logic [7:0]       od_q;
  logic [AW-1:0]    oa_q;

  logic             sck_w, rise, fall;
  logic             gap_ok;
  logic [AW-1:0]    cur_addr;
  logic             accept, use_fast, stall, gen_en, byte_done;

  assign req_ready = (state == ST_IDLE) && gap_ok;
  assign accept    = req_valid && req_ready;
  assign use_fast  = req_fast || (int'(cfg_div) < MIN_PLAIN_DIV);
  assign stall     = ov_q && !out_ready;
  assign gen_en    = ((state == ST_RUN) || (state == ST_FINISH)) && !(stall && !sck_w);
  assign byte_done = rise && (state == ST_RUN) && in_data && (bcnt == 3'd7);

  flash_rd_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .en  (gen_en),
    .div (cfg_div),
    .sck (sck_w),
    .rise(rise),
    .fall(fall)
  );

  flash_rd_addr_track #(.AW(AW), .ARRAY_AW(ARRAY_AW)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_addr(req_addr),
    .step     (byte_done),
    .cur      (cur_addr)
  );

  flash_rd_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk (clk),
    .rst (rst),
    .cs_n(cs_n_q),
    .gap (cfg_gap),
    .ok  (gap_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tx       <= '0;
      hdr_left <= '0;
      in_data  <= 1'b0;
      bcnt     <= '0;
      rx       <= '0;
      rem      <= '0;
      cs_n_q   <= 1'b1;
      done_q   <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
      oa_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (ov_q && out_ready) begin
        ov_q <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (req_len == '0) begin
              done_q <= 1'b1;
            end else begin
              cs_n_q   <= 1'b0;
              tx       <= {(use_fast ? OP_FAST : OP_PLAIN), req_addr & ADDR_MASK, 8'h00};
              hdr_left <= use_fast ? HDR_W'(HDR_FAST) : HDR_W'(HDR_PLAIN);
              in_data  <= 1'b0;
              bcnt     <= '0;
              rem      <= req_len;
              state    <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (fall) begin
            tx <= {tx[TX_W-2:0], 1'b0};
          end
          if (rise) begin
            if (!in_data) begin
              hdr_left <= hdr_left - 1'b1;
              if (hdr_left == HDR_W'(1)) begin
                in_data <= 1'b1;
              end
            end else begin
              rx   <= {rx[6:0], spi_miso};
              bcnt <= bcnt + 1'b1;
              if (bcnt == 3'd7) begin
                ov_q <= 1'b1;
                od_q <= {rx[6:0], spi_miso};
                oa_q <= cur_addr;
                rem  <= rem - 1'b1;
                if (rem == LEN_W'(1)) begin
                  state <= ST_FINISH;
                end
              end
            end
          end
        end
        ST_FINISH: begin
          if (fall) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_sck   = sck_w;
  assign spi_mosi  = tx[TX_W-1];
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_addr  = oa_q;
  assign done      = done_q;

  // R5: SCK pulses only inside a transaction
  a_r5_sck_inside_cs: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  // R5: MOSI moves only while SCK is low
  a_r5_mosi_on_low: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> !spi_sck);

  // R6: pending byte held steady under backpressure
  a_r6_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

  // R8: SCK frozen low while a byte waits
  a_r8_pause_low: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !spi_sck) |=> !spi_sck);

  // R9: done marks chip-select release
  a_r9_done_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> done);

  // R10: chip select falls only once the gap timer agreed
  a_r10_gap_met: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> $past(gap_ok));

  // R11: no new request taken mid-transaction
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !req_ready);

  // R12: empty request finishes without touching the bus
  a_r12_zero_len: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_len == '0)) |=> (done && spi_cs_n));
endmodule

// File: tb/flash_rd_engine_bench.sv
module flash_rd_engine_bench;
  localparam logic [23:0] MASK = 24'h3FFFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_fast = 1'b0;
  logic [7:0]  cfg_div = 8'd3;
  logic [7:0]  cfg_gap = 8'd2;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b1;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [23:0] out_addr;
  logic        out_ready = 1'b0;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int ready_pct = 70;
  logic [23:0] exp_q[$];

  // bus-side flash model state
  int          sl_bits = 0;
  int          cs_falls = 0;
  int          dummy_bad = 0;
  int          mosi_bad = 0;
  logic [7:0]  sl_cmd = '0;
  logic [23:0] sl_addr = '0;

  always #10 clk = ~clk;

  flash_rd_engine u_flash_rd_engine (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_fast(req_fast),
    .cfg_div(cfg_div), .cfg_gap(cfg_gap),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .out_valid(out_valid), .out_data(out_data), .out_addr(out_addr),
    .out_ready(out_ready), .done(done)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ {a[21:16], 2'b01} ^ 8'h96;
  endfunction

  function automatic int hdr_of(input logic [7:0] op);
    return (op == 8'h0B) ? 40 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model: capture on rising SCK, reset on chip-select fall
  always @(negedge spi_cs_n or posedge spi_sck) begin
    if (spi_sck) begin
      if (!spi_cs_n) begin
        if (sl_bits < 8) sl_cmd = {sl_cmd[6:0], spi_mosi};
        else if (sl_bits < 32) sl_addr = {sl_addr[22:0], spi_mosi};
        else if (sl_bits < hdr_of(sl_cmd)) begin
          if (spi_mosi !== 1'b0) dummy_bad++;
        end else if (spi_mosi !== 1'b0) mosi_bad++;
        sl_bits++;
      end
    end else begin
      sl_bits = 0;
      cs_falls++;
    end
  end

  // flash model: drive MISO on falling SCK; ones (noise) during header, R13
  always @(negedge spi_sck) begin
    if (!spi_cs_n && sl_bits >= 8 && sl_bits >= hdr_of(sl_cmd)) begin
      int k;
      logic [7:0] b;
      k = sl_bits - hdr_of(sl_cmd);
      b = mem_byte((sl_addr + 24'(k / 8)) & MASK);
      spi_miso = b[7 - (k % 8)];
    end else begin
      spi_miso = 1'b1;
    end
  end

  // stream consumer, pause monitor, gap monitor
  bit   prev_stall = 1'b0;
  logic prev_sck = 1'b0;
  logic prev_cs = 1'b1;
  int   high_cnt = 1000;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && prev_sck == 1'b0) begin
        chk(spi_sck == 1'b0, "R8 sck held low while byte waits", spi_sck, 0);
      end
      if (prev_cs && !spi_cs_n) begin
        chk(high_cnt >= int'(cfg_gap), "R10 cs high gap", high_cnt, cfg_gap);
      end
      high_cnt = spi_cs_n ? high_cnt + 1 : 0;
      prev_cs  = spi_cs_n;
      out_ready = ($urandom_range(1, 100) <= ready_pct);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected byte", out_addr, 0);
        end else begin
          logic [23:0] ea;
          ea = exp_q.pop_front();
          chk(out_addr == ea, "R7 out_addr sequence/wrap", out_addr, ea);
          chk(out_data == mem_byte(ea), "R6 R13 out_data", out_data, mem_byte(ea));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_sck   = spi_sck;
    end
  end

  task automatic run_txn(input logic [23:0] a, input int len, input bit fast,
                         input int div, input int gap);
    int falls0;
    bit exp_fast;
    int guard;
    cfg_div = 8'(div);
    cfg_gap = 8'(gap);
    exp_fast = fast || ((200_000_000 / (2 * (div + 1))) > 33_000_000);
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 1000) begin @(negedge clk); guard++; end
    for (int i = 0; i < len; i++) exp_q.push_back((a + 24'(i)) & MASK);
    falls0 = cs_falls;
    dummy_bad = 0;
    mosi_bad = 0;
    req_addr = a; req_len = 16'(len); req_fast = fast; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R12 done after empty request", done, 1);
      chk(cs_falls == falls0 && spi_cs_n, "R12 no chip select", cs_falls - falls0, 0);
      return;
    end
    chk(req_ready == 1'b0, "R11 busy during transfer", req_ready, 0);
    guard = 0;
    while (!done && guard < 40000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R9 done seen", done, 1);
    chk(sl_cmd == (exp_fast ? 8'h0B : 8'h03), "R2 R3 R4 opcode", sl_cmd, exp_fast ? 8'h0B : 8'h03);
    chk(sl_addr == (a & MASK), "R2 R7 address on bus", sl_addr, a & MASK);
    chk(sl_bits == (exp_fast ? 40 : 32) + 8 * len, "R9 rising edge count",
        sl_bits, (exp_fast ? 40 : 32) + 8 * len);
    chk(dummy_bad == 0 && mosi_bad == 0, "R3 dummy and data mosi zero", dummy_bad + mosi_bad, 0);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R5 R9 released with sck low",
        {spi_cs_n, spi_sck}, 2'b10);
    guard = 0;
    while (exp_q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 bus idle in reset", {spi_cs_n, spi_sck}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R1 outputs quiet", {out_valid, done}, 0);
    chk(req_ready == 1'b1 && spi_cs_n == 1'b1, "R1 ready after reset", {req_ready, spi_cs_n}, 2'b11);

    run_txn(24'h123456, 4, 1'b0, 3, 2);     // R2 plain at 25 MHz
    run_txn(24'h00ABCD, 3, 1'b1, 0, 0);     // R3 fast at 100 MHz
    run_txn(24'h054321, 2, 1'b0, 1, 3);     // R4 promoted at 50 MHz
    run_txn(24'h0F0F0F, 2, 1'b0, 2, 1);     // R4 boundary 33.3 MHz
    run_txn(24'h3FFFFD, 6, 1'b1, 1, 4);     // R7 wrap
    run_txn(24'hFFFFFE, 3, 1'b0, 4, 5);     // R7 high bits dropped
    run_txn(24'h000100, 0, 1'b0, 3, 0);     // R12
    run_txn(24'h000200, 0, 1'b1, 0, 0);     // R12 back to back
    ready_pct = 10;
    run_txn(24'h3FFF00, 300, 1'b1, 0, 6);   // R8 heavy backpressure, long burst
    ready_pct = 100;
    run_txn(24'h200000, 5, 1'b0, 5, 7);     // R10 long gap

    for (int t = 0; t < 40; t++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if ($urandom_range(0, 3) == 0) a = 24'h3FFFF8 + 24'($urandom_range(0, 7));
      ready_pct = $urandom_range(30, 100);
      run_txn(a, $urandom_range(0, 12), 1'($urandom_range(0, 1)),
              $urandom_range(0, 4), $urandom_range(0, 6));
    end

    repeat (20) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule